// File: doc/BRIEF.md
# UART Transmit Priority Arbiter

This block decides which byte the UART transmit shift register takes next. Three sources compete: a software flow-control character (XON or XOFF) asked for by the flow-control logic, a single "send now" byte that software arms through the register interface, and the byte at the head of the transmit FIFO. When the shifter is idle and the transmitter is enabled, the block raises a one-cycle load strobe. On the same cycle it puts the winning byte on the load bus and acknowledges the winning source. A frame that is already being shifted is never interrupted. The shifter applies the current parity and stop-bit settings to every byte it loads, including the "send now" byte.

The "send now" byte needs a strict two-access sequence. Software first writes the arming control bit. The very next register access must then be a holding-register write, and that write captures the byte. Any other access in between cancels the arming, and a holding write that was not armed is passed on to the FIFO. The arming bit stays visible while the byte waits and clears itself when the shifter loads the byte.

The block also keeps track of a paused state. A received XOFF pauses FIFO traffic. A received XON resumes it. An optional mode lets any received character resume it. While paused, only FIFO bytes are held back.

Top module: `uart_tx_arbiter`

## Requirements
- R1: After reset, `load` is 0, `load_src` is 0 (none), `arm_bit` is 0 and `paused` is 0.
- R2: When `fc_req` is 1 and a load is allowed, the flow-control character wins over every other source. It is shown with `load_src` = 1 and `fc_take` = 1, and `load_data` equals `fc_char`.
- R3: A captured "send now" byte wins over the FIFO head. It is shown with `load_src` = 2, and `fifo_pop` is 0 on that cycle.
- R4: No load occurs while `shifter_idle` is 0, whatever the sources request.
- R5: No load occurs while `tx_enable` is 0.
- R6: Access kinds on `bus_kind` are 0 = other access, 1 = write of the arming bit, 2 = holding-register write. A holding write captures the "send now" byte only if it is the first access after an arming write. An access of kind 0 in between cancels the arming. A holding write that captures nothing raises `fifo_push` on that cycle.
- R7: `arm_bit` reads 1 from the arming write until the captured byte is loaded, and reads 0 from the next cycle. A later holding write then goes to the FIFO unless software arms again.
- R8: With `flow_en` = 1, a received character equal to XOFF (0x13) sets `paused` on the next cycle. While paused, FIFO bytes are not loaded, but flow-control characters and the "send now" byte still are.
- R9: A received XON (0x11) clears `paused`. With `xon_any_en` = 1, any received character other than XOFF also clears it. With `xon_any_en` = 0, other characters leave it set.
- R10: `load` lasts one cycle per accepted byte. The acknowledge of the chosen source (`fc_take` or `fifo_pop`) is raised on that same cycle and never without `load`.
- R11: With `load_src` = 3, `load_data` equals `fifo_head` and `fifo_pop` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_enable | input | 1 | Transmitter enabled |
| shifter_idle | input | 1 | Shift register free to take a byte |
| fc_req | input | 1 | Flow-control character pending |
| fc_char | input | 8 | Flow-control character to send |
| bus_valid | input | 1 | Register access strobe |
| bus_kind | input | 2 | Access kind: 0 other, 1 arm write, 2 holding write |
| bus_wdata | input | 8 | Write data of the access |
| fifo_empty | input | 1 | Transmit FIFO is empty |
| fifo_head | input | 8 | Byte at the FIFO head |
| flow_en | input | 1 | Software flow control enabled |
| xon_any_en | input | 1 | Any received character resumes |
| rx_valid | input | 1 | Received-character strobe |
| rx_char | input | 8 | Received character |
| load | output | 1 | Load strobe to the shifter |
| load_data | output | 8 | Byte to load |
| load_src | output | 2 | Winning source: 0 none, 1 flow, 2 immediate, 3 FIFO |
| fc_take | output | 1 | Flow-control character consumed |
| fifo_pop | output | 1 | FIFO head consumed |
| fifo_push | output | 1 | Holding write routed to the FIFO |
| arm_bit | output | 1 | Arming control bit as read back |
| paused | output | 1 | FIFO traffic paused by XOFF |

## Verification
On every cycle, the assertions check three gating rules: loads only on an idle shifter, never with the transmitter disabled, and never a FIFO pop while paused or without a load. They also check that a pending flow-control character is taken whenever a load is allowed, that the arming bit is clear one cycle after the immediate byte loads, and that an XOFF sets the paused state. Some behaviours depend on a sequence of accesses and can only be shown by the bench's directed scenarios. These are the arming sequence and its cancellation, the routing of unarmed holding writes to the FIFO, the immediate byte overtaking the FIFO head, and resuming by XON or by any character.

// File: rtl/uart_txarb_pkg.sv
package uart_txarb_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FLOW = 2'd1,
        SRC_IMM  = 2'd2,
        SRC_FIFO = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ACC_OTHER = 2'd0,
        ACC_ARM   = 2'd1,
        ACC_HOLD  = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        ARM_IDLE = 2'd0,
        ARM_WAIT = 2'd1,
        ARM_HELD = 2'd2
    } arm_state_e;

    typedef enum logic {
        FLOW_RUN  = 1'b0,
        FLOW_HALT = 1'b1
    } flow_state_e;
endpackage

// File: rtl/uart_arm_fsm.sv
module uart_arm_fsm
    import uart_txarb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic [1:0]    bus_kind,
    input  logic [DW-1:0] bus_wdata,
    input  logic          imm_taken,
    output logic          imm_pending,
    output logic [DW-1:0] imm_data,
    output logic          arm_bit,
    output logic          hold_to_fifo
);
    arm_state_e state_q, state_d;
    logic       is_arm, is_hold;

    assign is_arm  = bus_valid && (bus_kind == ACC_ARM);
    assign is_hold = bus_valid && (bus_kind == ACC_HOLD);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_IDLE: if (is_arm) state_d = ARM_WAIT;
            ARM_WAIT: begin
                if (is_hold)        state_d = ARM_HELD;
                else if (bus_valid && !is_arm) state_d = ARM_IDLE;
            end
            ARM_HELD: begin
                if (imm_taken) state_d = is_arm ? ARM_WAIT : ARM_IDLE;
            end
            default:  state_d = ARM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ARM_IDLE;
            imm_data <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ARM_WAIT && is_hold) imm_data <= bus_wdata;
        end
    end

    always_comb begin
        imm_pending  = 1'b0;
        arm_bit      = 1'b0;
        hold_to_fifo = 1'b0;
        unique case (state_q)
            ARM_IDLE: hold_to_fifo = is_hold;
            ARM_WAIT: arm_bit = 1'b1;
            ARM_HELD: begin
                arm_bit      = 1'b1;
                imm_pending  = 1'b1;
                hold_to_fifo = is_hold;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/uart_flow_track.sv
module uart_flow_track
    import uart_txarb_pkg::*;
#(
    parameter int          DW        = 8,
    parameter logic [DW-1:0] XON_CODE  = 8'h11,
    parameter logic [DW-1:0] XOFF_CODE = 8'h13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flow_en,
    input  logic          xon_any_en,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_char,
    output logic          paused
);
    flow_state_e state_q, state_d;
    logic        got_xoff, got_resume;

    assign got_xoff   = rx_valid && (rx_char == XOFF_CODE);
    assign got_resume = rx_valid && ((rx_char == XON_CODE) || xon_any_en);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLOW_RUN:  if (flow_en && got_xoff) state_d = FLOW_HALT;
            FLOW_HALT: if (!flow_en || (got_resume && !got_xoff)) state_d = FLOW_RUN;
            default:   state_d = FLOW_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLOW_RUN;
        else        state_q <= state_d;
    end

    assign paused = (state_q == FLOW_HALT);
endmodule

// File: rtl/uart_tx_select.sv
module uart_tx_select
    import uart_txarb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          tx_enable,
    input  logic          shifter_idle,
    input  logic          fc_req,
    input  logic [DW-1:0] fc_char,
    input  logic          imm_pending,
    input  logic [DW-1:0] imm_data,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_head,
    input  logic          paused,
    output logic          load,
    output logic [DW-1:0] load_data,
    output logic [1:0]    load_src,
    output logic          fc_take,
    output logic          imm_taken,
    output logic          fifo_pop
);
    src_e pick;
    logic go;

    assign go = tx_enable && shifter_idle;

    always_comb begin
        if (!go)                          pick = SRC_NONE;
        else if (fc_req)                  pick = SRC_FLOW;
        else if (imm_pending)             pick = SRC_IMM;
        else if (!fifo_empty && !paused)  pick = SRC_FIFO;
        else                              pick = SRC_NONE;
    end

    always_comb begin
        load_data = '0;
        fc_take   = 1'b0;
        imm_taken = 1'b0;
        fifo_pop  = 1'b0;
        unique case (pick)
            SRC_NONE: ;
            SRC_FLOW: begin load_data = fc_char;   fc_take   = 1'b1; end
            SRC_IMM:  begin load_data = imm_data;  imm_taken = 1'b1; end
            SRC_FIFO: begin load_data = fifo_head; fifo_pop  = 1'b1; end
            default: ;
        endcase
    end

    assign load     = (pick != SRC_NONE);
    assign load_src = pick;
endmodule

// File: rtl/uart_tx_arbiter.sv
module uart_tx_arbiter
    import uart_txarb_pkg::*;
#(
    parameter int            DW        = 8,
    parameter logic [DW-1:0] XON_CODE  = 8'h11,
    parameter logic [DW-1:0] XOFF_CODE = 8'h13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_enable,
    input  logic          shifter_idle,
    input  logic          fc_req,
    input  logic [DW-1:0] fc_char,
    input  logic          bus_valid,
    input  logic [1:0]    bus_kind,
    input  logic [DW-1:0] bus_wdata,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_head,
    input  logic          flow_en,
    input  logic          xon_any_en,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_char,
    output logic          load,
    output logic [DW-1:0] load_data,
    output logic [1:0]    load_src,
    output logic          fc_take,
    output logic          fifo_pop,
    output logic          fifo_push,
    output logic          arm_bit,
    output logic          paused
);
    logic          imm_pending, imm_taken;
    logic [DW-1:0] imm_data;

    uart_arm_fsm #(.DW(DW)) u_arm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_valid    (bus_valid),
        .bus_kind     (bus_kind),
        .bus_wdata    (bus_wdata),
        .imm_taken    (imm_taken),
        .imm_pending  (imm_pending),
        .imm_data     (imm_data),
        .arm_bit      (arm_bit),
        .hold_to_fifo (fifo_push)
    );

    uart_flow_track #(.DW(DW), .XON_CODE(XON_CODE), .XOFF_CODE(XOFF_CODE)) u_flow (
        .clk        (clk),
        .rst_n      (rst_n),
        .flow_en    (flow_en),
        .xon_any_en (xon_any_en),
        .rx_valid   (rx_valid),
        .rx_char    (rx_char),
        .paused     (paused)
    );

    uart_tx_select #(.DW(DW)) u_sel (
        .tx_enable    (tx_enable),
        .shifter_idle (shifter_idle),
        .fc_req       (fc_req),
        .fc_char      (fc_char),
        .imm_pending  (imm_pending),
        .imm_data     (imm_data),
        .fifo_empty   (fifo_empty),
        .fifo_head    (fifo_head),
        .paused       (paused),
        .load         (load),
        .load_data    (load_data),
        .load_src     (load_src),
        .fc_take      (fc_take),
        .imm_taken    (imm_taken),
        .fifo_pop     (fifo_pop)
    );
endmodule

// File: rtl/uart_tx_arbiter_chk.sv
module uart_tx_arbiter_chk #(
    parameter int            DW        = 8,
    parameter logic [DW-1:0] XOFF_CODE = 8'h13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_enable,
    input logic          shifter_idle,
    input logic          fc_req,
    input logic          fifo_empty,
    input logic          flow_en,
    input logic          rx_valid,
    input logic [DW-1:0] rx_char,
    input logic          load,
    input logic [1:0]    load_src,
    input logic          fc_take,
    input logic          fifo_pop,
    input logic          arm_bit,
    input logic          paused
);
    assert_load_needs_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> shifter_idle);

    assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |-> !load);

    assert_flow_char_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_req && tx_enable && shifter_idle) |-> (fc_take && load));

    assert_pop_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (load && !paused && !fifo_empty));

    assert_take_with_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fc_take |-> load);

    assert_arm_self_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_src == 2'd2) |=> !arm_bit || $past(load_src) != 2'd2);

    assert_xoff_pauses_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en && rx_valid && rx_char == XOFF_CODE) |=> paused);
endmodule

bind uart_tx_arbiter uart_tx_arbiter_chk #(.DW(DW), .XOFF_CODE(XOFF_CODE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_enable    (tx_enable),
    .shifter_idle (shifter_idle),
    .fc_req       (fc_req),
    .fifo_empty   (fifo_empty),
    .flow_en      (flow_en),
    .rx_valid     (rx_valid),
    .rx_char      (rx_char),
    .load         (load),
    .load_src     (load_src),
    .fc_take      (fc_take),
    .fifo_pop     (fifo_pop),
    .arm_bit      (arm_bit),
    .paused       (paused)
);

// File: tb/sim_uart_tx_arbiter.sv
`timescale 1ns/1ps
module sim_uart_tx_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_enable = 1'b0, shifter_idle = 1'b0, fc_req = 1'b0;
    logic [7:0] fc_char = 8'h00;
    logic       bus_valid = 1'b0;
    logic [1:0] bus_kind = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic       fifo_empty = 1'b1;
    logic [7:0] fifo_head = 8'h00;
    logic       flow_en = 1'b0, xon_any_en = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_char = 8'h00;
    logic       load, fc_take, fifo_pop, fifo_push, arm_bit, paused;
    logic [7:0] load_data;
    logic [1:0] load_src;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_tx_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .shifter_idle(shifter_idle),
        .fc_req(fc_req), .fc_char(fc_char), .bus_valid(bus_valid), .bus_kind(bus_kind),
        .bus_wdata(bus_wdata), .fifo_empty(fifo_empty), .fifo_head(fifo_head),
        .flow_en(flow_en), .xon_any_en(xon_any_en), .rx_valid(rx_valid), .rx_char(rx_char),
        .load(load), .load_data(load_data), .load_src(load_src), .fc_take(fc_take),
        .fifo_pop(fifo_pop), .fifo_push(fifo_push), .arm_bit(arm_bit), .paused(paused)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    // one register access; push_exp is the expected fifo_push during it
    task automatic access(input logic [1:0] kind, input logic [7:0] d, input logic push_exp);
        @(negedge clk);
        bus_valid = 1'b1; bus_kind = kind; bus_wdata = d;
        #1;
        chk("R6 fifo_push on access", fifo_push, push_exp);
        @(negedge clk);
        bus_valid = 1'b0; bus_kind = 2'd0;
    endtask

    task automatic rx(input logic [7:0] c);
        @(negedge clk);
        rx_valid = 1'b1; rx_char = c;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk("R1 load", load, 0);
        chk("R1 load_src", load_src, 0);
        chk("R1 arm_bit", arm_bit, 0);
        chk("R1 paused", paused, 0);
    endtask

    task automatic t_fifo();
        fifo_empty = 1'b0; fifo_head = 8'hA7; shifter_idle = 1'b1; tx_enable = 1'b1;
        settle();
        chk("R11 src", load_src, 3);
        chk("R11 data", load_data, 8'hA7);
        chk("R11 pop", fifo_pop, 1);
        chk("R10 fc_take idle", fc_take, 0);
        shifter_idle = 1'b0;
        settle();
        chk("R4 busy no load", load, 0);
        chk("R10 no pop without load", fifo_pop, 0);
        shifter_idle = 1'b1; tx_enable = 1'b0;
        settle();
        chk("R5 disabled no load", load, 0);
        tx_enable = 1'b1; shifter_idle = 1'b0; fifo_empty = 1'b1;
    endtask

    task automatic t_immediate();
        fifo_empty = 1'b0; fifo_head = 8'h31;
        access(2'd1, 8'h00, 0);
        chk("R7 arm_bit set", arm_bit, 1);
        access(2'd2, 8'h5C, 0);
        chk("R7 arm_bit while held", arm_bit, 1);
        chk("R4 held waits", load, 0);
        shifter_idle = 1'b1;
        #1;
        chk("R3 imm src", load_src, 2);
        chk("R3 imm data", load_data, 8'h5C);
        chk("R3 no pop", fifo_pop, 0);
        settle();
        chk("R7 arm_bit cleared", arm_bit, 0);
        chk("R11 fifo after imm", load_src, 3);
        chk("R11 fifo data", load_data, 8'h31);
        shifter_idle = 1'b0;
        access(2'd2, 8'h66, 1);   // not re-armed: goes to FIFO (R7)
        chk("R7 no rearm", arm_bit, 0);
        fifo_empty = 1'b1;
    endtask

    task automatic t_cancel();
        access(2'd1, 8'h00, 0);
        access(2'd0, 8'h00, 0);
        chk("R6 cancelled", arm_bit, 0);
        access(2'd2, 8'h77, 1);
        shifter_idle = 1'b1;
        settle();
        chk("R6 nothing captured", load, 0);
        shifter_idle = 1'b0;
    endtask

    task automatic t_priority();
        fifo_empty = 1'b0; fifo_head = 8'h44;
        access(2'd1, 8'h00, 0);
        access(2'd2, 8'h99, 0);
        fc_req = 1'b1; fc_char = 8'h13; shifter_idle = 1'b1;
        #1;
        chk("R2 flow src", load_src, 1);
        chk("R2 flow data", load_data, 8'h13);
        chk("R2 fc_take", fc_take, 1);
        fc_req = 1'b0;
        #1;
        chk("R3 imm after flow", load_src, 2);
        chk("R3 imm data", load_data, 8'h99);
        settle();
        chk("R11 fifo last", load_src, 3);
        shifter_idle = 1'b0; fifo_empty = 1'b1;
    endtask

    task automatic t_pause();
        flow_en = 1'b1; fifo_empty = 1'b0; fifo_head = 8'h55;
        rx(8'h13);
        chk("R8 paused", paused, 1);
        shifter_idle = 1'b1;
        #1;
        chk("R8 fifo blocked", load, 0);
        fc_req = 1'b1; fc_char = 8'h11;
        #1;
        chk("R8 flow while paused", load_src, 1);
        fc_req = 1'b0; shifter_idle = 1'b0;
        access(2'd1, 8'h00, 0);
        access(2'd2, 8'hE1, 0);
        shifter_idle = 1'b1;
        #1;
        chk("R8 imm while paused", load_src, 2);
        settle();
        chk("R8 still blocked", load, 0);
        shifter_idle = 1'b0;
        rx(8'h41);
        chk("R9 other char keeps pause", paused, 1);
        rx(8'h11);
        chk("R9 xon resumes", paused, 0);
        shifter_idle = 1'b1;
        #1;
        chk("R9 fifo resumes", load_src, 3);
        shifter_idle = 1'b0;
        xon_any_en = 1'b1;
        rx(8'h13);
        chk("R8 xoff with any-mode", paused, 1);
        rx(8'h41);
        chk("R9 any char resumes", paused, 0);
        xon_any_en = 1'b0; flow_en = 1'b0; fifo_empty = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fifo();
        t_immediate();
        t_cancel();
        t_priority();
        t_pause();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule